// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device out of power-up. A one-cycle start pulse launches a fixed command order on the SDRAM command pins. First comes a precharge of all banks. Eight auto-refresh commands follow, then a mode register write that places a caller-supplied value on the address bus. Recovery gaps separate the commands. After the last gap the block enters normal operation, raises a sticky ready flag and begins periodic refresh.

The refresh pace comes from two counters in cascade. A prescaler divides the clock by `pre_div_i + 1`. Its ticks drive a refresh timer that expires every `rfr_period_i + 1` ticks. Each expiry raises a refresh request, and the block services it with one auto-refresh command while the bus is idle.

States and transitions: `ST_IDLE` goes to `ST_PRE` on start. `ST_PRE` goes to `ST_PRE_WAIT`. `ST_PRE_WAIT` goes to `ST_AREF` when its gap ends. `ST_AREF` goes to `ST_AREF_WAIT`. `ST_AREF_WAIT` goes back to `ST_AREF` until eight refreshes have been issued, and then to `ST_MRS`. `ST_MRS` goes to `ST_MRS_WAIT`. `ST_MRS_WAIT` goes to `ST_RUN` after two cycles. `ST_RUN` goes to `ST_RUN_REF` while a request is pending. `ST_RUN_REF` goes to `ST_RUN_WAIT`. `ST_RUN_WAIT` goes back to `ST_RUN` when its gap ends.

Top module: `sdinit_seq`

## Requirements
- R1: After reset, and until start is seen, the command pins show NOP, the address bus is zero, and ready and rfr_req are low.
- R2: The cycle after start is sampled in ST_IDLE, the pins show a precharge with address bit 10 set and all other address bits zero.
- R3: The precharge is followed by max(trp_i,1) NOP cycles, then the first auto-refresh.
- R4: Exactly eight auto-refresh commands are issued during initialisation. Each is followed by max(trfc_i,1) NOP cycles. The address bus is zero during each of them.
- R5: A mode register write with the address equal to mode_val_i comes right after the eighth refresh gap. Exactly two NOP cycles follow it.
- R6: ready rises in the cycle after the second NOP that follows the mode register write, and stays high until reset.
- R7: No refresh request or auto-refresh is made before ready. From the cycle ready rises (cycle E), rfr_req is high at cycle E+k*(pre_div_i+1)*(rfr_period_i+1), and an auto-refresh is issued one cycle later, for every k>=1.
- R8: A start pulse outside ST_IDLE has no effect: no extra command appears, whether the pulse comes during initialisation or in normal operation.
- R9: The {cs_n,ras_n,cas_n,we_n} codes are NOP 4'b0111, precharge 4'b0010, auto-refresh 4'b0001 and mode register write 4'b0000. Every command lasts one cycle and is followed by NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only in ST_IDLE |
| trp_i | input | WW | Precharge recovery in cycles (0 acts as 1) |
| trfc_i | input | WW | Refresh recovery in cycles (0 acts as 1) |
| pre_div_i | input | PW | Prescaler limit, divides by value+1 |
| rfr_period_i | input | TW | Refresh timer limit in prescaler ticks, value+1 |
| mode_val_i | input | AW | Value driven on the address bus during the mode register write |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | AW | SDRAM address bus |
| rfr_req | output | 1 | Periodic refresh request pending |
| ready | output | 1 | Initialisation finished, sticky until reset |

## Verification
The scoreboard predicts the cycle, code and address of every non-NOP command, so any miscount is reported. A sequencer that issues seven or nine refreshes, or leaves the MRS gap at the wrong length, shifts or adds commands. Zero recovery values are applied so that a design which waits zero cycles, or underflows its wait counter, gives itself away. Start pulses are applied mid-sequence and after ready, which exposes a design that restarts. The one-cycle spacing between rfr_req and the serviced refresh, together with the full cascaded period, catches an off-by-one in the prescaler or timer and a refresh enabled too early.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_AREF,
        ST_AREF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_RUN,
        ST_RUN_REF,
        ST_RUN_WAIT
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sd_cmd_t;

    localparam int MRS_HOLD = 2;

endpackage

// File: rtl/sdinit_divider.sv
// Free-running wrap counter: counts enabled increments 0..limit, flags the wrap.
module sdinit_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;
    logic         at_limit;

    assign at_limit = (cnt == limit);
    assign wrap     = en && inc && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_limit ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdinit_wait_cnt.sv
// Gap timer: after a load of len, done is high once max(len,1) cycles have passed.
module sdinit_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? '0 : len - 1'b1;
        end else if (!done) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int AW         = 13,
    parameter int PW         = 8,
    parameter int TW         = 12,
    parameter int WW         = 4,
    parameter int INIT_REFS  = 8,
    parameter int AP_BIT     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [WW-1:0] trp_i,
    input  logic [WW-1:0] trfc_i,
    input  logic [PW-1:0] pre_div_i,
    input  logic [TW-1:0] rfr_period_i,
    input  logic [AW-1:0] mode_val_i,
    output logic          sd_cs_n,
    output logic          sd_ras_n,
    output logic          sd_cas_n,
    output logic          sd_we_n,
    output logic [AW-1:0] sd_addr,
    output logic          rfr_req,
    output logic          ready
);
    localparam int RCW = $clog2(INIT_REFS + 1);
    localparam logic [RCW-1:0] REF_LAST = RCW'(INIT_REFS);

    seq_state_t    state, state_nx;
    sd_cmd_t       cmd;
    logic [RCW-1:0] ref_cnt;
    logic          ready_q;
    logic          pend_q;
    logic          tick, expire;
    logic          w_load, w_done;
    logic [WW-1:0] w_len;

    // Refresh pacing: prescaler feeds the refresh timer, both held while not ready
    sdinit_divider #(.W(PW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready_q),
        .inc   (1'b1),
        .limit (pre_div_i),
        .wrap  (tick)
    );

    sdinit_divider #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready_q),
        .inc   (tick),
        .limit (rfr_period_i),
        .wrap  (expire)
    );

    // One gap timer shared by every recovery wait
    always_comb begin
        w_load = 1'b0;
        w_len  = trfc_i;
        unique case (state)
            ST_PRE:              begin w_load = 1'b1; w_len = trp_i; end
            ST_AREF, ST_RUN_REF: begin w_load = 1'b1; w_len = trfc_i; end
            ST_MRS:              begin w_load = 1'b1; w_len = WW'(MRS_HOLD); end
            default:             begin w_load = 1'b0; w_len = trfc_i; end
        endcase
    end

    sdinit_wait_cnt #(.W(WW)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (w_load),
        .len   (w_len),
        .done  (w_done)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_i) state_nx = ST_PRE;
            ST_PRE:       state_nx = ST_PRE_WAIT;
            ST_PRE_WAIT:  if (w_done) state_nx = ST_AREF;
            ST_AREF:      state_nx = ST_AREF_WAIT;
            ST_AREF_WAIT: if (w_done) state_nx = (ref_cnt == REF_LAST) ? ST_MRS : ST_AREF;
            ST_MRS:       state_nx = ST_MRS_WAIT;
            ST_MRS_WAIT:  if (w_done) state_nx = ST_RUN;
            ST_RUN:       if (pend_q) state_nx = ST_RUN_REF;
            ST_RUN_REF:   state_nx = ST_RUN_WAIT;
            ST_RUN_WAIT:  if (w_done) state_nx = ST_RUN;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ref_cnt <= '0;
            ready_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_AREF) ref_cnt <= ref_cnt + 1'b1;
            if (state == ST_MRS_WAIT && w_done) ready_q <= 1'b1;
            if (expire) pend_q <= 1'b1;
            else if (state == ST_RUN_REF) pend_q <= 1'b0;
        end
    end

    // Output decode (Moore)
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        unique case (state)
            ST_PRE: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_AREF, ST_RUN_REF: cmd = CMD_AREF;
            ST_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = mode_val_i;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n  = cmd[3];
    assign sd_ras_n = cmd[2];
    assign sd_cas_n = cmd[1];
    assign sd_we_n  = cmd[0];
    assign rfr_req  = pend_q;
    assign ready    = ready_q;

endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
    parameter int AW = 13,
    parameter int AP_BIT = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sd_cs_n,
    input logic          sd_ras_n,
    input logic          sd_cas_n,
    input logic          sd_we_n,
    input logic [AW-1:0] sd_addr,
    input logic [AW-1:0] mode_val_i,
    input logic          rfr_req,
    input logic          ready
);
    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_PRE_ALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> sd_addr[AP_BIT]); // R2
    AST_MRS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (sd_addr == mode_val_i)); // R5
    AST_READY_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(pins, 3) == 4'b0000)); // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R6
    AST_NO_EARLY_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !rfr_req); // R7
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != 4'b0111) |=> (pins == 4'b0111)); // R9
endmodule

bind sdinit_seq sdinit_checker #(.AW(AW), .AP_BIT(AP_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .mode_val_i (mode_val_i),
    .rfr_req    (rfr_req),
    .ready      (ready)
);

// File: tb/sim_sdinit_seq.sv
`timescale 1ns/1ps
module sim_sdinit_seq;
    localparam int AW = 13, PW = 8, TW = 12, WW = 4;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_AREF = 4'b0001, C_MRS = 4'b0000;

    typedef struct {
        logic [3:0]    cmd;
        logic [AW-1:0] addr;
        int            cyc;
        string         tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [WW-1:0] trp_i = '0, trfc_i = '0;
    logic [PW-1:0] pre_div_i = '0;
    logic [TW-1:0] rfr_period_i = '0;
    logic [AW-1:0] mode_val_i = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rfr_req, ready;
    logic [AW-1:0] sd_addr;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdinit_seq #(.AW(AW), .PW(PW), .TW(TW), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .trp_i(trp_i), .trfc_i(trfc_i),
        .pre_div_i(pre_div_i), .rfr_period_i(rfr_period_i), .mode_val_i(mode_val_i),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .rfr_req(rfr_req), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Monitor: every non-NOP command must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] pins;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (pins != C_NOP) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8/R9", "unexpected command", int'(pins), int'(C_NOP));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(pins == e.cmd, e.tag, "command code", int'(pins), int'(e.cmd));
                    chk(sd_addr == e.addr, e.tag, "address", int'(sd_addr), int'(e.addr));
                    chk(cyc == e.cyc, e.tag, "command cycle", cyc, e.cyc);
                end
            end
        end
    end

    task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input int t, input string tag);
        exp_t e;
        e.cmd = c; e.addr = a; e.cyc = t; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic run_case(input int trp, input int trfc, input int pdiv, input int tper,
                            input logic [AW-1:0] mval, input int nper);
        int wrp, wrfc, per, t0, m, e;
        wrp  = (trp  == 0) ? 1 : trp;
        wrfc = (trfc == 0) ? 1 : trfc;
        per  = (pdiv + 1) * (tper + 1);
        @(negedge clk);
        rst_n = 1'b0;
        trp_i = WW'(trp); trfc_i = WW'(trfc);
        pre_div_i = PW'(pdiv); rfr_period_i = TW'(tper); mode_val_i = mval;
        sb.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: idle state after reset
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "idle pins",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
        chk(sd_addr == '0, "R1", "idle address", int'(sd_addr), 0);
        chk(!ready, "R1", "idle ready", int'(ready), 0);
        chk(!rfr_req, "R1", "idle rfr_req", int'(rfr_req), 0);
        // Expected sequence
        t0 = cyc;
        push(C_PRE, AW'(1) << 10, t0 + 1, "R2");
        for (int i = 0; i < 8; i++)
            push(C_AREF, '0, t0 + 2 + wrp + i * (1 + wrfc), (i == 0) ? "R3" : "R4");
        m = t0 + 2 + wrp + 8 * (1 + wrfc);
        push(C_MRS, mval, m, "R5");
        e = m + 3;
        for (int k = 1; k <= nper; k++)
            push(C_AREF, '0, e + k * per + 1, "R7");
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R8: start during the init sequence is ignored
        wait_until(t0 + 6);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_until(e - 1);
        chk(!ready, "R6", "ready before entry", int'(ready), 0);
        chk(!rfr_req, "R7", "rfr_req before ready", int'(rfr_req), 0);
        @(negedge clk);
        chk(ready, "R6", "ready on entry", int'(ready), 1);
        // R8: start in normal operation is ignored
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_until(e + per - 1);
        chk(!rfr_req, "R7", "rfr_req one cycle early", int'(rfr_req), 0);
        @(negedge clk);
        chk(rfr_req, "R7", "rfr_req at expiry", int'(rfr_req), 1);
        wait_until(e + nper * per + 4);
        chk(sb.size() == 0, "R4/R7", "commands still expected", sb.size(), 0);
        chk(ready, "R6", "ready sticky", int'(ready), 1);
    endtask

    initial begin
        run_case(2, 3, 3, 4, 13'h0032, 3);
        run_case(0, 0, 0, 9, 13'h01AB, 4);
        run_case(5, 1, 1, 6, 13'h1FFF, 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule